// File: doc/BRIEF.md
# Modulo 65537 Multiplicative Inverse Unit

This block takes a 16-bit operand and returns its multiplicative inverse modulo 2^16+1 (65537). Decryption subkeys for a 64-bit block cipher that works on 16-bit words are built from such inverses. The word value 0 stands for 2^16. The modulus is prime, so Euler's theorem gives the inverse as the operand raised to the power 2^16-1.

That exponent is all ones. The unit therefore starts from the operand itself. It then makes fifteen rounds, and each round squares the running value and multiplies it by the operand. One combinational modulo multiplier serves every round. An accumulator register keeps the running value between cycles.

A request is a one-cycle `start` with the operand on `operand`. The answer comes back after a fixed 30 cycles, marked by a one-cycle `done`. A caller that needs a list of key inverses (18 of them, for example) can hold `start` high. The unit then accepts the next operand in each `done` cycle, with no gap between jobs.

Top module: `mod_inverse_unit`

## Requirements
- R1: When `done` is high, `result` times the operand accepted with that job is congruent to 1 modulo 65537. The code 0 stands for 65536 on both words.
- R2: An operand of 0 (meaning 65536, which is congruent to -1) yields a result of 0.
- R3: An operand of 1 yields a result of 1.
- R4: `done` goes high for exactly one cycle. It is seen 30 rising edges after the edge that accepted `start`.
- R5: `busy` is high for the 30 cycles after acceptance. It is low in the cycle where `done` is high, and it only falls together with a `done` pulse.
- R6: A `start` that is high while `busy` is high is ignored. It does not change the running job's result or timing, and it does not queue a second job.
- R7: `result` keeps its value in every cycle except the one in which `done` rises.
- R8: A synchronous active-low reset clears `busy`, `done` and `result` to 0. It abandons any job in progress, and no `done` follows from that job.
- R9: A `start` that is high in the same cycle as `done` is accepted. Chained jobs therefore give one `done` every 31 cycles, and each result is correct for the operand presented at its own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new inverse; sampled only while idle |
| operand | input | 16 | Word to invert (0 encodes 65536) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: `result` has just been updated |
| result | output | 16 | Inverse of the last accepted operand, held between jobs |

## Verification
Two events can fall in the same cycle: a job finishing with its `done` pulse, and the controller accepting a new `start`. The bench provokes this by holding `start` high through eighteen chained jobs. It presents each next operand only in the `done` cycle and drives unrelated values on `operand` while the unit is busy. The bench judges the outcome two ways. The spacing between `done` pulses must be exactly 31 cycles. Each result must satisfy the modulo-65537 congruence with the operand presented in the `done` cycle, not with any value driven while busy.

// File: rtl/mod_inverse_pkg.sv
// Shared types for the modulo 2^W+1 inverse unit.
// Assumes: nothing beyond IEEE 1800-2017.
package mod_inverse_pkg;

    // Controller phase: idle, squaring round half, multiply-by-operand half.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SQR  = 2'd1,
        PH_MUL  = 2'd2
    } phase_e;

    // Per-cycle datapath commands issued by the controller.
    typedef struct packed {
        logic load;     // capture operand into operand and accumulator regs
        logic square;   // accumulator <= accumulator * accumulator
        logic mul_x;    // accumulator <= accumulator * operand
        logic finish;   // result <= final product
    } dp_ctrl_t;

endpackage

// File: rtl/mod_inverse_mulmod.sv
// Combinational multiplier modulo 2^W+1.
// Word value 0 encodes 2^W (congruent to -1). Nonzero operands use the
// low-minus-high reduction of the 2W-bit product; a zero operand turns the
// product into a negation, computed as 1 - other (mod 2^W).
// Assumes: 2^W+1 is prime (W = 16 for the intended use).
module mod_inverse_mulmod #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  lo;
    logic [W-1:0]  hi;
    logic          borrow;

    // Full-width product of the two words.
    assign prod   = PW'(a) * PW'(b);
    assign lo     = prod[W-1:0];
    assign hi     = prod[PW-1:W];
    assign borrow = (lo < hi);

    // Reduce, with separate paths for operands that encode -1.
    always_comb begin
        if (a == '0) begin
            y = W'(1) - b;
        end else if (b == '0) begin
            y = W'(1) - a;
        end else begin
            y = lo - hi + {{(W-1){1'b0}}, borrow};
        end
    end

endmodule

// File: rtl/mod_inverse_seq.sv
// Controller for the exponent-(2^W-1) chain: after load, W-1 rounds of
// square-then-multiply. Emits datapath commands, busy and a one-cycle done.
// Assumes: start is only acted on while idle; done is registered.
module mod_inverse_seq
    import mod_inverse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output dp_ctrl_t ctrl,
    output logic     busy,
    output logic     done
);
    localparam int ROUNDS = W - 1;
    localparam int SW     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [SW-1:0] LAST = SW'(ROUNDS - 1);

    phase_e        phase_q;
    logic [SW-1:0] round_q;
    logic          last_round;

    assign last_round = (round_q == LAST);

    // Decode the current phase into datapath commands.
    always_comb begin
        ctrl.load   = (phase_q == PH_IDLE) && start;
        ctrl.square = (phase_q == PH_SQR);
        ctrl.mul_x  = (phase_q == PH_MUL);
        ctrl.finish = (phase_q == PH_MUL) && last_round;
    end

    // Advance phase and round counter; raise done on the final multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            round_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SQR;
                        round_q <= '0;
                    end
                end
                PH_SQR: phase_q <= PH_MUL;
                PH_MUL: begin
                    if (last_round) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end else begin
                        round_q <= round_q + 1'b1;
                        phase_q <= PH_SQR;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/mod_inverse_dp.sv
// Datapath: operand register, running accumulator, held result, and the
// single shared modulo multiplier whose second input is steered by ctrl.
// Assumes: at most one of load/square/mul_x is high in a cycle.
module mod_inverse_dp
    import mod_inverse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dp_ctrl_t     ctrl,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result
);
    logic [W-1:0] x_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] mul_b;
    logic [W-1:0] mul_y;

    // Second multiplier input: accumulator when squaring, else the operand.
    assign mul_b = ctrl.square ? acc_q : x_q;

    mod_inverse_mulmod #(.W(W)) u_mul (
        .a (acc_q),
        .b (mul_b),
        .y (mul_y)
    );

    // Capture operand and seed the accumulator; update it each round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            acc_q <= '0;
        end else if (ctrl.load) begin
            x_q   <= operand;
            acc_q <= operand;
        end else if (ctrl.square || ctrl.mul_x) begin
            acc_q <= mul_y;
        end
    end

    // Hold the published result until the next job finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (ctrl.finish) begin
            result <= mul_y;
        end
    end

endmodule

// File: rtl/mod_inverse_unit.sv
// Top: multiplicative inverse modulo 2^W+1 by raising the operand to the
// power 2^W-1. Fixed latency of 2*(W-1) cycles from acceptance to done.
// Assumes: W chosen so that 2^W+1 is prime; 0 encodes 2^W.
module mod_inverse_unit
    import mod_inverse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    dp_ctrl_t ctrl;

    mod_inverse_seq #(.W(W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy),
        .done  (done)
    );

    mod_inverse_dp #(.W(W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .operand (operand),
        .result  (result)
    );

endmodule

// File: rtl/mod_inverse_chk.sv
// Checker for mod_inverse_unit, attached by bind. Tracks the accepted
// operand and the cycles spent busy, and checks results and handshake.
// Assumes: only the top-level ports are visible.
module mod_inverse_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] operand,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int LAT = 2 * (W - 1);
    localparam int CW  = $clog2(LAT + 2);
    localparam longint unsigned MODV = (64'd1 << W) + 64'd1;

    logic          seen;
    logic [CW-1:0] busy_cnt;
    logic [W-1:0]  held_x;

    // Map a word to the integer it stands for (0 means 2^W).
    function automatic longint unsigned wval(input logic [W-1:0] v);
        return (v == '0) ? (64'd1 << W) : longint'(v);
    endfunction

    // Record the accepted operand and count busy cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            busy_cnt <= '0;
            held_x   <= '0;
        end else begin
            seen <= 1'b1;
            if (start && !busy) begin
                busy_cnt <= '0;
                held_x   <= operand;
            end else if (busy) begin
                busy_cnt <= busy_cnt + 1'b1;
            end
        end
    end

    a_r1_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((wval(result) * wval(held_x)) % MODV) == 64'd1));

    a_r2_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && held_x == '0) |-> (result == '0));

    a_r3_one_maps_one: assert property (@(posedge clk) disable iff (!rst_n)
        (done && held_x == W'(1)) |-> (result == W'(1)));

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == CW'(LAT)));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !done) |-> $stable(result));

endmodule

bind mod_inverse_unit mod_inverse_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .busy    (busy),
    .done    (done),
    .result  (result)
);

// File: tb/tb_mod_inverse_unit.sv
module tb_mod_inverse_unit;
    localparam int W   = 16;
    localparam int LAT = 30;
    localparam longint M = 65537;
    localparam int NV  = 10;

    // {operand, expected inverse}
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0000, 32'h0001_0001, 32'h0002_8001, 32'h0003_5556,
        32'h0004_C001, 32'h0005_6667, 32'h0100_FF01, 32'h8000_FFFF,
        32'hFFFF_8000, 32'hFF01_0100
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [W-1:0] operand;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    mod_inverse_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint wv(input logic [W-1:0] v);
        return (v == '0) ? 65536 : longint'(v);
    endfunction

    function automatic longint modprod(input logic [W-1:0] a, input logic [W-1:0] b);
        return (wv(a) * wv(b)) % M;
    endfunction

    // Issue one job and wait for done; lat = edges from acceptance to done.
    task automatic run_one(input logic [W-1:0] op, output int lat);
        @(negedge clk); start = 1'b1; operand = op;
        @(negedge clk); start = 1'b0; lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk); lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        rst_n = 1'b0; start = 1'b0; operand = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(busy == 1'b0, "R8 busy in reset", busy, 0);
        chk(done == 1'b0, "R8 done in reset", done, 0);
        chk(result == '0, "R8 result in reset", result, 0);
        rst_n = 1'b1;

        // Table of known inverses.
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] op, ex;
            string tag;
            op = VEC[i][31:16]; ex = VEC[i][15:0];
            tag = (op == 0) ? "R2 zero" : (op == 1) ? "R3 one" : "R1 table";
            run_one(op, lat);
            chk(result == ex, tag, result, ex);
            chk(modprod(result, op) == 1, "R1 congruence", modprod(result, op), 1);
            chk(lat == LAT, "R4 latency", lat, LAT);
            @(negedge clk);
            chk(done == 1'b0, "R4 single pulse", done, 0);
        end

        // Random operands, congruence.
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] op;
            op = W'($urandom);
            run_one(op, lat);
            chk(modprod(result, op) == 1, "R1 random", modprod(result, op), 1);
        end

        // R5: busy profile across one job.
        begin
            int bcnt; int n;
            bcnt = 0; n = 0;
            @(negedge clk); start = 1'b1; operand = 16'd7;
            @(negedge clk); start = 1'b0;
            while (!done && n < 100) begin
                if (busy) bcnt++;
                @(negedge clk); n++;
            end
            chk(bcnt == LAT, "R5 busy cycles", bcnt, LAT);
            chk(busy == 1'b0, "R5 busy low at done", busy, 0);
        end

        // R6/R7: start while busy is ignored; result held during job.
        begin
            logic [W-1:0] prev;
            bit stable_ok;
            int n;
            @(negedge clk);
            prev = result; stable_ok = 1;
            start = 1'b1; operand = 16'd3;
            @(negedge clk); start = 1'b0; n = 0;
            while (!done && n < 100) begin
                if (n == 4) begin start = 1'b1; operand = 16'd5; end
                else begin start = 1'b0; operand = W'($urandom); end
                if (result != prev) stable_ok = 0;
                @(negedge clk); n++;
            end
            start = 1'b0;
            chk(stable_ok, "R7 result held while busy", stable_ok, 1);
            chk(result == 16'h5556, "R6 ignored start keeps result", result, 16'h5556);
            chk(n == LAT, "R6 ignored start keeps timing", n, LAT);
            prev = result;
            repeat (3) begin
                @(negedge clk);
                chk(busy == 1'b0, "R6 no queued job", busy, 0);
                chk(result == prev, "R7 result held while idle", result, prev);
            end
        end

        // R9: eighteen chained jobs with start held high.
        begin
            logic [W-1:0] ops [18];
            int since;
            for (int k = 0; k < 18; k++) ops[k] = (k == 0) ? '0 : W'($urandom);
            @(negedge clk); start = 1'b1; operand = ops[0];
            since = 0;
            for (int k = 0; k < 18; k++) begin
                do begin
                    @(negedge clk); since++;
                    if (!done) operand = W'($urandom);
                end while (!done && since < 100);
                chk(modprod(result, ops[k]) == 1, "R9 chained result",
                    modprod(result, ops[k]), 1);
                chk(since == LAT + 1, "R9 done spacing", since, LAT + 1);
                since = 0;
                if (k < 17) operand = ops[k + 1];
            end
            start = 1'b0;
        end

        // R8: reset in mid-job.
        begin
            bit saw_done;
            @(negedge clk); start = 1'b1; operand = 16'd9;
            @(negedge clk); start = 1'b0;
            repeat (10) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk(busy == 1'b0, "R8 busy after mid reset", busy, 0);
            chk(done == 1'b0, "R8 done after mid reset", done, 0);
            chk(result == '0, "R8 result after mid reset", result, 0);
            rst_n = 1'b1;
            saw_done = 0;
            repeat (40) begin
                @(negedge clk);
                if (done || busy) saw_done = 1;
            end
            chk(!saw_done, "R8 abandoned job silent", saw_done, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule